// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one input-capture channel of a general-purpose timer. A 4-bit select picks one of sixteen external pins. The chosen pin passes through a synchronizer, and a downcounting noise filter then samples it on a sample strobe. A new filtered level is accepted only after enough consecutive samples agree. Rising and falling edges of the filtered level are detected, and a two-bit polarity setting decides which of them count.

The active edge of this channel is always sent to a slave-mode controller. A coded source select then decides what acts as the capture event:
- this channel's own edge,
- the neighbouring channel's edges, qualified by this channel's polarity,
- an internal trigger pulse,
- or nothing, when the channel is in output mode.

An event prescaler passes every 1st, 2nd, 4th or 8th event. On each passed event, while the channel is enabled, the free-running counter value is taken into a shadow register. One cycle later it moves to the visible capture register, and the capture flag is set. A capture that arrives while the flag is still set raises the overcapture flag. Both flags are cleared by pulses on dedicated inputs.

Top module: `tcap_channel`

## Requirements
- R1: `pin_sel` chooses which bit of `pin_in` feeds the channel; transitions on any other pin change neither `edge_out` nor the capture register.
- R2: The filter takes a sample only in cycles where `samp_en` is 1. It changes its level after N consecutive samples that differ from the current level, where N = 1 for `flt_code` 0 and N = 2*`flt_code` otherwise. A pulse that lasts fewer than N samples produces no edge and no capture.
- R3: `pol` encodes the active edges: 00 = rising, 01 = falling, 11 = both, 10 = rising only.
- R4: `edge_out` is high for one cycle on each active edge of the filtered own input, whatever the values of `src_sel`, `psc_sel` and `chan_en`.
- R5: `src_sel` picks the capture event. 01 selects the own active edge. 10 selects `nb_rise`/`nb_fall`, qualified by `pol`. 11 selects `trig_in`.
- R6: With `src_sel` = 00, no capture occurs.
- R7: `psc_sel` 00/01/10/11 captures on every 1st/2nd/4th/8th selected event.
- R8: The prescaler count restarts when `chan_en` is 0 or when `psc_sel` changes, so the first capture after either comes on exactly the programmed event count.
- R9: While `chan_en` is 0, no capture occurs.
- R10: A capture stores the `cnt_in` value seen at the clock edge where the event is registered (edge 1 after a trigger or neighbour pulse is driven; edge 3+N after an own pin change). `cap_val` shows that value one cycle later.
- R11: Each capture sets `cap_flag`. A capture while `cap_flag` is already 1 sets `ovr_flag`. `flag_clr` and `ovr_clr` clear the flags, and a capture in the same cycle takes priority over a clear.
- R12: After reset, `cap_val` is 0, both flags are 0 and `edge_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | External input pins |
| pin_sel | input | 4 | Pin select |
| samp_en | input | 1 | Filter sample strobe |
| flt_code | input | 4 | Filter length code |
| pol | input | 2 | Edge polarity code |
| src_sel | input | 2 | Capture source code |
| psc_sel | input | 2 | Event prescaler code |
| chan_en | input | 1 | Capture enable |
| nb_rise | input | 1 | Neighbour filtered rising-edge pulse |
| nb_fall | input | 1 | Neighbour filtered falling-edge pulse |
| trig_in | input | 1 | Internal trigger pulse |
| cnt_in | input | 16 | Free-running counter value |
| flag_clr | input | 1 | Clear capture flag |
| ovr_clr | input | 1 | Clear overcapture flag |
| edge_out | output | 1 | Active own edge, to slave-mode controller |
| own_rise | output | 1 | Filtered rising edge, to neighbour channel |
| own_fall | output | 1 | Filtered falling edge, to neighbour channel |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
Pin transitions are applied under each polarity code, which separates rising, falling and both-edge selection. Toggling an unselected pin confirms that it has no effect. Two pulse widths are used with a six-sample filter: one sample short of N, and long enough to pass. Together with a stalled sample strobe, these separate real filtering from plain pipeline delay. Triggers, neighbour pulses and pin edges are then sent under every source code and every prescaler ratio, including a ratio change in the middle of a count. A scoreboard predicts each captured counter value, so a wrong latency, a dropped event or an extra event all show up as value mismatches.

// File: rtl/tcap_pkg.sv
// Package: shared types and helpers for the input capture channel.
// Assumes the filter code is 4 bits wide and the longest filter is 30 samples.
package tcap_pkg;

    localparam int FLT_CODE_W = 4;
    localparam int FLT_CNT_W  = 5;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_OWN   = 2'b01,
        SRC_NEIGH = 2'b10,
        SRC_TRIG  = 2'b11
    } src_e;

    // Reload value N-1 of the filter downcounter: N = 1 for code 0, else 2*code.
    function automatic logic [FLT_CNT_W-1:0] flt_reload(input logic [FLT_CODE_W-1:0] code);
        logic [FLT_CNT_W-1:0] n;
        n = {code, 1'b0};
        return (code == '0) ? '0 : n - 1'b1;
    endfunction

endpackage

// File: rtl/tcap_insel.sv
// Module: selects one external pin and brings it into the clock domain.
// Assumes SYNC_STAGES >= 2; pins are asynchronous to clk.
module tcap_insel #(
    parameter int NPIN        = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NPIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [SEL_W-1:0] pin_sel,
    output logic             pin_sync
);

    logic             raw;
    logic [SYNC_STAGES-1:0] sh;

    // Pick the selected pin.
    always_comb raw = pin_in[pin_sel];

    // First synchronizer stage takes the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= raw;
    end

    // Remaining synchronizer stages, one per extra stage.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= sh[g-1];
        end
    end

    assign pin_sync = sh[SYNC_STAGES-1];

endmodule

// File: rtl/tcap_filter.sv
// Module: digital noise filter built as a downcounter.
// A new level is taken after N consecutive differing samples; samples are
// taken only on samp_en. Assumes flt_code is quasi-static while in use.
module tcap_filter
    import tcap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  samp_en,
    input  logic [FLT_CODE_W-1:0] flt_code,
    input  logic                  s_in,
    output logic                  flt
);

    logic [FLT_CNT_W-1:0] cnt;
    logic [FLT_CNT_W-1:0] reload;

    // Reload value from the filter code.
    always_comb reload = flt_reload(flt_code);

    // Count down on disagreeing samples; flip the level when the count is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt <= 1'b0;
            cnt <= reload;
        end else if (samp_en) begin
            if (s_in == flt) begin
                cnt <= reload;
            end else if (cnt == '0) begin
                flt <= s_in;
                cnt <= reload;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R2: the level moves only on a sample strobe.
    a_r2_flt_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (flt != $past(flt)) |-> $past(samp_en));

    // R2: the level moves only toward a sample that disagreed.
    a_r2_flt_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (flt != $past(flt)) |-> ($past(s_in) != $past(flt)));

endmodule

// File: rtl/tcap_edge.sv
// Module: edge detector with polarity select and capture source mux.
// Neighbour edges arrive as raw rise/fall pulses and are qualified by this
// channel's polarity. Assumes trig_in is a one-cycle pulse.
module tcap_edge
    import tcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt,
    input  logic [1:0] pol,
    input  src_e       src,
    input  logic       nb_rise,
    input  logic       nb_fall,
    input  logic       trig_in,
    output logic       own_rise,
    output logic       own_fall,
    output logic       own_edge,
    output logic       evt
);

    logic flt_q;
    logic use_rise;
    logic use_fall;
    logic nb_edge;

    // Previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= 1'b0;
        else        flt_q <= flt;
    end

    // Decode polarity: 00 rise, 01 fall, 11 both, 10 rise.
    always_comb begin
        use_rise = !pol[0] || pol[1];
        use_fall = pol[0];
    end

    // Raw and qualified edges of both channels.
    always_comb begin
        own_rise = flt && !flt_q;
        own_fall = !flt && flt_q;
        own_edge = (own_rise && use_rise) || (own_fall && use_fall);
        nb_edge  = (nb_rise && use_rise) || (nb_fall && use_fall);
    end

    // Capture source mux.
    always_comb begin
        unique case (src)
            SRC_OWN:   evt = own_edge;
            SRC_NEIGH: evt = nb_edge;
            SRC_TRIG:  evt = trig_in;
            default:   evt = 1'b0;
        endcase
    end

    // R6: output mode yields no capture event.
    a_r6_none_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |-> !evt);

endmodule

// File: rtl/tcap_presc.sv
// Module: event prescaler passing every 2**psc-th event.
// Count restarts while disabled or on the cycle the setting changes.
module tcap_presc #(
    parameter int PSC_W = 2,
    localparam int PC_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    input  logic             evt,
    output logic             fire
);

    logic [PSC_W-1:0] psc_q;
    logic [PC_W-1:0]  pcnt;
    logic [PC_W-1:0]  lim;
    logic             restart;

    // Last count value before a pass, and the restart condition.
    always_comb begin
        lim     = PC_W'((1 << psc) - 1);
        restart = !en || (psc != psc_q);
        fire    = evt && !restart && (pcnt == lim);
    end

    // Track the setting to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc;
    end

    // Count events, wrapping at the pass.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pcnt <= '0;
        else if (evt)          pcnt <= (pcnt == lim) ? '0 : pcnt + 1'b1;
    end

    // R9: nothing passes while disabled.
    a_r9_fire_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> en);

    // R8: nothing passes on the cycle the ratio changes.
    a_r8_no_fire_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(psc_q) != psc_q) |-> !$past(fire));

endmodule

// File: rtl/tcap_channel.sv
// Module: top of the input capture channel.
// Chains pin select, filter, edge/source select and prescaler, then latches
// cnt_in into a shadow register and moves it to cap_val one cycle later.
// Assumes cnt_in is synchronous to clk.
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int NPIN        = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PSC_W       = 2,
    localparam int SEL_W      = $clog2(NPIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIN-1:0]       pin_in,
    input  logic [SEL_W-1:0]      pin_sel,
    input  logic                  samp_en,
    input  logic [FLT_CODE_W-1:0] flt_code,
    input  logic [1:0]            pol,
    input  logic [1:0]            src_sel,
    input  logic [PSC_W-1:0]      psc_sel,
    input  logic                  chan_en,
    input  logic                  nb_rise,
    input  logic                  nb_fall,
    input  logic                  trig_in,
    input  logic [CNT_W-1:0]      cnt_in,
    input  logic                  flag_clr,
    input  logic                  ovr_clr,
    output logic                  edge_out,
    output logic                  own_rise,
    output logic                  own_fall,
    output logic [CNT_W-1:0]      cap_val,
    output logic                  cap_flag,
    output logic                  ovr_flag
);

    logic             pin_sync;
    logic             flt;
    logic             evt;
    logic             fire;
    logic             pend;
    logic [CNT_W-1:0] shadow;
    src_e             src;

    always_comb src = src_e'(src_sel);

    tcap_insel #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_insel (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
        .pin_sync(pin_sync)
    );

    tcap_filter u_filter (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .flt_code(flt_code),
        .s_in(pin_sync), .flt(flt)
    );

    tcap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .flt(flt), .pol(pol), .src(src),
        .nb_rise(nb_rise), .nb_fall(nb_fall), .trig_in(trig_in),
        .own_rise(own_rise), .own_fall(own_fall), .own_edge(edge_out),
        .evt(evt)
    );

    tcap_presc #(.PSC_W(PSC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .psc(psc_sel), .evt(evt),
        .fire(fire)
    );

    // Shadow stage: take the counter on a passed event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            shadow <= '0;
        end else begin
            pend <= fire;
            if (fire) shadow <= cnt_in;
        end
    end

    // Visible stage: move the shadow into cap_val.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_val <= '0;
        else if (pend) cap_val <= shadow;
    end

    // Capture flag: set by capture, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (pend)     cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end

    // Overcapture flag: set by a capture that finds the flag still set.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr_flag <= 1'b0;
        else if (pend && cap_flag) ovr_flag <= 1'b1;
        else if (ovr_clr)          ovr_flag <= 1'b0;
    end

    // R11: a capture always leaves the flag set.
    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> cap_flag);

    // R11: a capture on a set flag leaves overcapture set.
    a_r11_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cap_flag) |=> ovr_flag);

    // R10: the visible register takes the shadowed counter value.
    a_r10_shadow_move: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (cap_val == $past(shadow)));

    // R10: cap_val changes only on a capture.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pend) |-> $stable(cap_val));

endmodule

// File: tb/tcap_channel_test.sv
`timescale 1ns/1ps
module tcap_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic [3:0]  pin_sel = 4'd5;
    logic        samp_en = 1'b1;
    logic [3:0]  flt_code = '0;
    logic [1:0]  pol = 2'b00;
    logic [1:0]  src_sel = 2'b01;
    logic [1:0]  psc_sel = 2'b00;
    logic        chan_en = 1'b1;
    logic        nb_rise = 1'b0, nb_fall = 1'b0, trig_in = 1'b0;
    logic [15:0] cnt_in = '0;
    logic        flag_clr = 1'b0, ovr_clr = 1'b0;
    logic        edge_out, own_rise, own_fall, cap_flag, ovr_flag;
    logic [15:0] cap_val;

    always #2 clk = ~clk;
    always @(posedge clk) cnt_in <= cnt_in + 1'b1;

    tcap_channel uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
        .samp_en(samp_en), .flt_code(flt_code), .pol(pol), .src_sel(src_sel),
        .psc_sel(psc_sel), .chan_en(chan_en), .nb_rise(nb_rise),
        .nb_fall(nb_fall), .trig_in(trig_in), .cnt_in(cnt_in),
        .flag_clr(flag_clr), .ovr_clr(ovr_clr), .edge_out(edge_out),
        .own_rise(own_rise), .own_fall(own_fall), .cap_val(cap_val),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    int          errors = 0;
    int          checks = 0;
    string       cur_req = "R12";
    logic [15:0] exp_q[$];
    logic [15:0] last_cap = '0;
    logic [15:0] exp_v;
    int          edge_seen = 0;
    int          exp_edges = 0;
    int          m_cnt = 0;
    int          m_ratio = 1;
    logic        m_en = 1'b1;
    logic [1:0]  m_src = 2'b01;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Monitor: counts edges and pops the scoreboard on each cap_val change.
    always @(negedge clk) begin
        if (rst_n) begin
            if (edge_out) edge_seen++;
            if (cap_val != last_cap) begin
                last_cap = cap_val;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected capture got %0h expected none", cur_req, cap_val);
                end else begin
                    exp_v = exp_q.pop_front();
                    if (exp_v !== cap_val) begin
                        errors++;
                        $display("FAIL %s: capture got %0h expected %0h", cur_req, cap_val, exp_v);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nflt();
        return (flt_code == 0) ? 1 : 2 * flt_code;
    endfunction

    function automatic bit pol_ok(input bit rise);
        return rise ? (!pol[0] || pol[1]) : pol[0];
    endfunction

    // Model one selected event from source s captured with value v.
    task automatic ev(input logic [15:0] v, input logic [1:0] s);
        if (m_en && m_src == s && s != 2'b00) begin
            m_cnt++;
            if (m_cnt == m_ratio) begin
                m_cnt = 0;
                exp_q.push_back(v);
            end
        end
    endtask

    task automatic drive_pin(input int idx, input logic lvl, input int hold);
        logic [15:0] v;
        bit r, f;
        v = cnt_in;
        r = lvl && !pin_in[idx];
        f = !lvl && pin_in[idx];
        pin_in[idx] = lvl;
        if (idx == pin_sel && ((r && pol_ok(1)) || (f && pol_ok(0)))) begin
            exp_edges++;
            ev(v + 16'(2 + nflt()), 2'b01);
        end
        tick(hold);
    endtask

    task automatic glitch(input int idx, input int len);
        pin_in[idx] = 1'b1;
        tick(len);
        pin_in[idx] = 1'b0;
        tick(nflt() + 6);
    endtask

    task automatic trig_ev();
        trig_in = 1'b1;
        ev(cnt_in, 2'b11);
        tick(1);
        trig_in = 1'b0;
        tick(2);
    endtask

    task automatic nb_ev(input bit rise);
        if (rise) nb_rise = 1'b1; else nb_fall = 1'b1;
        if (pol_ok(rise)) ev(cnt_in, 2'b10);
        tick(1);
        nb_rise = 1'b0;
        nb_fall = 1'b0;
        tick(2);
    endtask

    task automatic set_en(input logic b);
        chan_en = b; m_en = b; m_cnt = 0;
        tick(2);
    endtask

    task automatic set_psc(input logic [1:0] p);
        psc_sel = p; m_ratio = 1 << p; m_cnt = 0;
        tick(2);
    endtask

    task automatic set_src(input logic [1:0] s);
        src_sel = s; m_src = s;
        tick(1);
    endtask

    task automatic drain(input string req);
        tick(40);
        check({req, " pending captures"}, exp_q.size(), 0);
        check({req, " edge_out count"}, edge_seen, exp_edges);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R12: state held in reset
        check("R12 cap_val", int'(cap_val), 0);
        check("R12 cap_flag", int'(cap_flag), 0);
        check("R12 ovr_flag", int'(ovr_flag), 0);
        check("R12 edge_out", int'(edge_out), 0);
        rst_n = 1'b1;
        tick(4);

        // R5 / R10 / R3: own source, rising only
        cur_req = "R10";
        drive_pin(5, 1'b1, 8);
        drive_pin(5, 1'b0, 8);
        drain("R10");

        // R1: unselected pin ignored
        cur_req = "R1";
        drive_pin(3, 1'b1, 8);
        drive_pin(3, 1'b0, 8);
        drain("R1");

        // R3: each polarity code
        cur_req = "R3";
        for (int p = 1; p < 4; p++) begin
            pol = 2'(p);
            tick(1);
            drive_pin(5, 1'b1, 8);
            drive_pin(5, 1'b0, 8);
            drain("R3");
        end

        // R2: filter with N = 6, glitch one sample short, then long pulses
        cur_req = "R2";
        pol = 2'b11;
        flt_code = 4'd3;
        tick(4);
        glitch(5, 3);
        glitch(5, 5);
        drain("R2 glitch");
        drive_pin(5, 1'b1, 14);
        drive_pin(5, 1'b0, 14);
        drain("R2 long");

        // R2: stalled sample strobe
        flt_code = 4'd0;
        pol = 2'b00;
        tick(2);
        samp_en = 1'b0;
        pin_in[5] = 1'b1;
        tick(8);
        check("R2 stalled edge_out", edge_seen, exp_edges);
        check("R2 stalled capture", int'(exp_q.size()), 0);
        exp_edges++;
        ev(cnt_in + 16'd1, 2'b01);
        samp_en = 1'b1;
        tick(8);
        drive_pin(5, 1'b0, 8);
        drain("R2 resume");

        // R7: every ratio with trigger source
        cur_req = "R7";
        set_src(2'b11);
        for (int p = 0; p < 4; p++) begin
            set_en(1'b0);
            set_psc(2'(p));
            set_en(1'b1);
            repeat (9) trig_ev();
            drain("R7");
        end

        // R8: ratio change mid-count restarts the count
        cur_req = "R8";
        set_en(1'b0);
        set_psc(2'b11);
        set_en(1'b1);
        repeat (5) trig_ev();
        set_psc(2'b01);
        trig_ev();
        check("R8 no capture after one event", int'(exp_q.size()), 0);
        trig_ev();
        drain("R8");

        // R4: slave edge output ignores prescaler and source
        cur_req = "R4";
        set_psc(2'b11);
        set_src(2'b01);
        repeat (3) begin
            drive_pin(5, 1'b1, 8);
            drive_pin(5, 1'b0, 8);
        end
        drain("R4");
        set_psc(2'b00);

        // R9: disabled channel
        cur_req = "R9";
        set_en(1'b0);
        drive_pin(5, 1'b1, 8);
        drive_pin(5, 1'b0, 8);
        set_src(2'b11);
        repeat (3) trig_ev();
        drain("R9");
        set_en(1'b1);

        // R6: output mode
        cur_req = "R6";
        set_src(2'b00);
        repeat (3) trig_ev();
        drive_pin(5, 1'b1, 8);
        drive_pin(5, 1'b0, 8);
        drain("R6");

        // R5: neighbour and trigger sources
        cur_req = "R5";
        set_src(2'b10);
        nb_ev(1'b1);
        nb_ev(1'b0);
        trig_ev();
        pol = 2'b01;
        tick(1);
        nb_ev(1'b1);
        nb_ev(1'b0);
        drain("R5 neighbour");
        pol = 2'b00;
        set_src(2'b11);
        trig_ev();
        drive_pin(5, 1'b1, 8);
        drive_pin(5, 1'b0, 8);
        drain("R5 trigger");

        // R11: flags
        cur_req = "R11";
        flag_clr = 1'b1; ovr_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0; ovr_clr = 1'b0;
        tick(1);
        check("R11 flag cleared", int'(cap_flag), 0);
        check("R11 ovr cleared", int'(ovr_flag), 0);
        trig_ev();
        check("R11 flag set", int'(cap_flag), 1);
        check("R11 no ovr on first", int'(ovr_flag), 0);
        trig_ev();
        check("R11 ovr set", int'(ovr_flag), 1);
        flag_clr = 1'b1; ovr_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0; ovr_clr = 1'b0;
        tick(1);
        check("R11 both cleared", int'(cap_flag) + int'(ovr_flag), 0);
        trig_in = 1'b1;
        ev(cnt_in, 2'b11);
        tick(1);
        trig_in = 1'b0;
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R11 capture beats clear", int'(cap_flag), 1);
        check("R11 ovr stays clear", int'(ovr_flag), 0);
        drain("R11");

        finish_run();
    end

endmodule